// File: doc/BRIEF.md
# Runahead Invalid-Value Register Scoreboard

This block keeps one poison flag per architectural register while the core runs speculatively past a long-latency miss. Instructions are presented in program order as they retire. For each one the block looks up the flags of up to two source registers and reports whether the instruction can retire without executing. It then writes the resulting invalidity into the flag of the destination register, so poison spreads along dependence chains and is cut off wherever a result does not depend on its inputs.

The load that started speculative mode returns immediately with a poisoned destination. A load whose address register is poisoned is presented with that register as its first source and therefore also yields poisoned data. An instruction flagged as producing a constant writes a clean value and clears the destination flag. A single recovery strobe, issued when the checkpoint is restored, wipes every flag in one cycle. Outside speculative mode the block leaves its state alone and never asks for a skip. Register values and the execution datapath are not part of the block.

Top module: `inv_scoreboard`

## Requirements
- R1: After reset every flag in `invBits` is 0 and `skipExec` is 0.
- R2: A retiring instruction with `isTrigger` = 1 in speculative mode drives `skipExec` = 1 in the same cycle, and the destination flag reads 1 after the next rising clock edge, whatever its sources or `isConst`.
- R3: In speculative mode, a retiring non-constant instruction with at least one counted source whose flag is 1 drives `skipExec` = 1 in the same cycle and sets its destination flag to 1 at the next edge. A load presents its address register as source A, so a poisoned address yields a poisoned destination.
- R4: A retiring instruction with `isConst` = 1 and `isTrigger` = 0 drives `skipExec` = 0 and clears its destination flag at the next edge, even when its sources are poisoned.
- R5: A retiring non-constant, non-trigger instruction whose counted sources all carry flag 0 drives `skipExec` = 0 and clears its destination flag.
- R6: A source counts only when its used bit is 1 and its index is nonzero; register 0's flag always reads 0, and writes addressed to register 0 leave it 0.
- R7: When `recover` is 1 at a rising edge, every flag reads 0 after that edge, overriding a write presented in the same cycle.
- R8: While `runahead` is 0, `skipExec` is 0 and no flag changes.
- R9: While `retireValid` is 0, `skipExec` is 0 and no flag changes.
- R10: An instruction with `dstWrite` = 0 changes no flag, though `skipExec` still follows R2 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| runahead | input | 1 | 1 while the core executes speculatively |
| recover | input | 1 | Checkpoint restore strobe, clears all flags |
| retireValid | input | 1 | An instruction retires this cycle |
| srcAIdx | input | 5 | First source register index (address register for loads) |
| srcAUsed | input | 1 | First source is read by the instruction |
| srcBIdx | input | 5 | Second source register index |
| srcBUsed | input | 1 | Second source is read by the instruction |
| dstIdx | input | 5 | Destination register index |
| dstWrite | input | 1 | Instruction writes a destination |
| isConst | input | 1 | Result does not depend on the sources |
| isTrigger | input | 1 | Instruction is the miss load that started speculation |
| skipExec | output | 1 | Instruction may retire without executing |
| invBits | output | 32 | Current poison flag of each register |

## Verification
The hardest case to reach from the ports is a long poison chain that gets cut in the middle by a constant write, and then a recovery that lands in the same cycle as another poisoning retire. Single directed steps do not build that state. Directed sequences therefore build a chain through a trigger load, a dependent add and a load through a poisoned address, then cut it with a constant move and clear it with a recovery during a trigger. A long seeded random run, weighted toward speculative mode and short chains over a few registers, then mixes all of these with register 0 and unused-source cases while a bench model tracks every flag.

// File: rtl/inv_sb_pkg.sv
package inv_sb_pkg;

  // Strobes passed from control to the flag array each cycle
  typedef struct packed {
    logic wrEn;    // write the destination flag
    logic clrAll;  // wipe all flags (checkpoint restored)
    logic wrVal;   // value written to the destination flag
  } sbStrobe_t;

endpackage

// File: rtl/inv_sb_bits.sv
module inv_sb_bits
  import inv_sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  sbStrobe_t           strobe,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [IDX_W-1:0]    rdIdxA,
  input  logic [IDX_W-1:0]    rdIdxB,
  output logic                rdInvA,
  output logic                rdInvB,
  output logic [NUM_REGS-1:0] invBits
);

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : gFlag
      if (g == 0) begin : gZero
        // register 0 is hardwired clean
        assign invBits[g] = 1'b0;
      end else begin : gReg
        logic flagQ;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            flagQ <= 1'b0;
          end else if (strobe.clrAll) begin
            flagQ <= 1'b0;
          end else if (strobe.wrEn && (wrIdx == IDX_W'(g))) begin
            flagQ <= strobe.wrVal;
          end
        end
        assign invBits[g] = flagQ;
      end
    end
  endgenerate

  assign rdInvA = invBits[rdIdxA];
  assign rdInvB = invBits[rdIdxB];

  // R7
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.clrAll)) |-> (invBits == '0));

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.wrEn) && !$past(strobe.clrAll) && ($past(wrIdx) != '0))
      |-> (invBits[$past(wrIdx)] == $past(strobe.wrVal)));

  // R10
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobe.wrEn) && !$past(strobe.clrAll))
      |-> (invBits == $past(invBits)));

endmodule

// File: rtl/inv_sb_ctrl.sv
module inv_sb_ctrl
  import inv_sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runahead,
  input  logic             recover,
  input  logic             retireValid,
  input  logic [IDX_W-1:0] srcAIdx,
  input  logic             srcAUsed,
  input  logic [IDX_W-1:0] srcBIdx,
  input  logic             srcBUsed,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic             dstWrite,
  input  logic             isConst,
  input  logic             isTrigger,
  input  logic             rdInvA,
  input  logic             rdInvB,
  output sbStrobe_t        strobe,
  output logic             skipExec
);

  logic active;
  logic srcAHit;
  logic srcBHit;
  logic resultInv;

  assign active  = runahead && retireValid;
  assign srcAHit = srcAUsed && (srcAIdx != '0) && rdInvA;
  assign srcBHit = srcBUsed && (srcBIdx != '0) && rdInvB;

  // trigger load wins over everything; constant results break the chain
  assign resultInv = isTrigger || ((srcAHit || srcBHit) && !isConst);

  assign skipExec      = active && resultInv;
  assign strobe.wrEn   = active && dstWrite && (dstIdx != '0);
  assign strobe.wrVal  = resultInv;
  assign strobe.clrAll = recover;

  // R8
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runahead |-> (!skipExec && !strobe.wrEn));

  // R9
  no_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    !retireValid |-> (!skipExec && !strobe.wrEn));

  // R4
  const_exec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isConst && !isTrigger) |-> !skipExec);

  // R2
  trigger_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && isTrigger) |-> skipExec);

endmodule

// File: rtl/inv_scoreboard.sv
module inv_scoreboard
  import inv_sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runahead,
  input  logic                recover,
  input  logic                retireValid,
  input  logic [IDX_W-1:0]    srcAIdx,
  input  logic                srcAUsed,
  input  logic [IDX_W-1:0]    srcBIdx,
  input  logic                srcBUsed,
  input  logic [IDX_W-1:0]    dstIdx,
  input  logic                dstWrite,
  input  logic                isConst,
  input  logic                isTrigger,
  output logic                skipExec,
  output logic [NUM_REGS-1:0] invBits
);

  sbStrobe_t strobe;
  logic      rdInvA;
  logic      rdInvB;

  inv_sb_ctrl #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .runahead    (runahead),
    .recover     (recover),
    .retireValid (retireValid),
    .srcAIdx     (srcAIdx),
    .srcAUsed    (srcAUsed),
    .srcBIdx     (srcBIdx),
    .srcBUsed    (srcBUsed),
    .dstIdx      (dstIdx),
    .dstWrite    (dstWrite),
    .isConst     (isConst),
    .isTrigger   (isTrigger),
    .rdInvA      (rdInvA),
    .rdInvB      (rdInvB),
    .strobe      (strobe),
    .skipExec    (skipExec)
  );

  inv_sb_bits #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bits (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrIdx   (dstIdx),
    .rdIdxA  (srcAIdx),
    .rdIdxB  (srcBIdx),
    .rdInvA  (rdInvA),
    .rdInvB  (rdInvB),
    .invBits (invBits)
  );

endmodule

// File: tb/inv_scoreboard_bench.sv
module inv_scoreboard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 32;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int RAND_OPS   = 3000;

  logic                clk = 1'b0;
  logic                rstN;
  logic                runahead, recover, retireValid;
  logic [IDX_W-1:0]    srcAIdx, srcBIdx, dstIdx;
  logic                srcAUsed, srcBUsed, dstWrite, isConst, isTrigger;
  logic                skipExec;
  logic [NUM_REGS-1:0] invBits;

  logic [NUM_REGS-1:0] expBits;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inv_scoreboard #(.NUM_REGS(NUM_REGS)) u_inv_scoreboard (
    .clk(clk), .rstN(rstN), .runahead(runahead), .recover(recover),
    .retireValid(retireValid), .srcAIdx(srcAIdx), .srcAUsed(srcAUsed),
    .srcBIdx(srcBIdx), .srcBUsed(srcBUsed), .dstIdx(dstIdx),
    .dstWrite(dstWrite), .isConst(isConst), .isTrigger(isTrigger),
    .skipExec(skipExec), .invBits(invBits)
  );

  function automatic logic srcCounts(logic used, logic [IDX_W-1:0] idx,
                                     logic [NUM_REGS-1:0] flags);
    return used && (idx != 0) && flags[idx];
  endfunction

  function automatic logic expResult(logic [NUM_REGS-1:0] flags);
    logic anySrc;
    anySrc = srcCounts(srcAUsed, srcAIdx, flags) || srcCounts(srcBUsed, srcBIdx, flags);
    return isTrigger || (anySrc && !isConst);
  endfunction

  function automatic logic expSkip(logic [NUM_REGS-1:0] flags);
    return runahead && retireValid && expResult(flags);
  endfunction

  function automatic logic [NUM_REGS-1:0] nextBits(logic [NUM_REGS-1:0] flags);
    logic [NUM_REGS-1:0] n;
    n = flags;
    if (recover) return '0;
    if (runahead && retireValid && dstWrite && dstIdx != 0) n[dstIdx] = expResult(flags);
    return n;
  endfunction

  task automatic check(bit ok, string tag, logic [NUM_REGS-1:0] act, logic [NUM_REGS-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idleInputs();
    runahead = 1'b1; recover = 1'b0; retireValid = 1'b1;
    srcAIdx = '0; srcBIdx = '0; dstIdx = '0;
    srcAUsed = 1'b0; srcBUsed = 1'b0; dstWrite = 1'b1;
    isConst = 1'b0; isTrigger = 1'b0;
  endtask

  // inputs are set at a falling edge; skip is combinational, flags update at the next rise
  task automatic step(string tag);
    logic es;
    #1;
    es = expSkip(expBits);
    check(skipExec === es, {tag, " skip"}, {31'd0, skipExec}, {31'd0, es});
    expBits = nextBits(expBits);
    @(posedge clk);
    @(negedge clk);
    check(invBits === expBits, {tag, " flags"}, invBits, expBits);
  endtask

  task automatic op(string tag, logic trig, logic cst,
                    logic au, logic [IDX_W-1:0] a, logic bu, logic [IDX_W-1:0] b,
                    logic [IDX_W-1:0] d);
    idleInputs();
    isTrigger = trig; isConst = cst;
    srcAUsed = au; srcAIdx = a; srcBUsed = bu; srcBIdx = b; dstIdx = d;
    step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    idleInputs();
    rstN = 1'b0;
    expBits = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(invBits === '0, "R1 reset flags", invBits, '0);
    runahead = 1'b0; #1;
    check(skipExec === 1'b0, "R1 reset skip", {31'd0, skipExec}, '0);
    @(negedge clk);

    // R2 trigger load poisons r5
    op("R2 trigger", 1, 0, 0, 0, 0, 0, 5'd5);
    // R3 dependent add r7 = r5 + r3
    op("R3 add poisoned", 0, 0, 1, 5'd5, 1, 5'd3, 5'd7);
    // R3 load through poisoned address r7 into r9
    op("R3 load poisoned addr", 0, 0, 1, 5'd7, 0, 0, 5'd9);
    // R6 zero index and unused sources do not count
    op("R6 zero src", 0, 0, 1, 5'd0, 1, 5'd3, 5'd10);
    op("R6 unused src", 0, 0, 1, 5'd3, 0, 5'd5, 5'd11);
    op("R6 write r0", 1, 0, 0, 0, 0, 0, 5'd0);
    op("R6 read r0", 0, 0, 1, 5'd0, 1, 5'd0, 5'd12);
    // R4 constant move into r5 with poisoned source
    op("R4 const", 0, 1, 1, 5'd7, 0, 0, 5'd5);
    // R2 trigger wins over const
    op("R2 trigger const", 1, 1, 0, 0, 0, 0, 5'd13);
    // R5 clean sources clear r7
    op("R5 clean srcs", 0, 0, 1, 5'd3, 1, 5'd4, 5'd7);

    // R8 outside speculative mode
    idleInputs(); runahead = 1'b0; isTrigger = 1'b1; dstIdx = 5'd12;
    step("R8 idle mode");
    idleInputs(); runahead = 1'b0; srcAUsed = 1'b1; srcAIdx = 5'd9; dstIdx = 5'd9;
    step("R8 idle clear");
    // R9 no retire
    idleInputs(); retireValid = 1'b0; isTrigger = 1'b1; dstIdx = 5'd12;
    step("R9 no retire");
    // R10 no destination write
    idleInputs(); dstWrite = 1'b0; srcAUsed = 1'b1; srcAIdx = 5'd9; dstIdx = 5'd14;
    step("R10 no dst");
    // R7 recover during a trigger
    idleInputs(); recover = 1'b1; isTrigger = 1'b1; dstIdx = 5'd14;
    step("R7 recover");
    check(invBits === '0, "R7 all clear", invBits, '0);

    // random mix over a small register window to build chains
    for (int i = 0; i < RAND_OPS; i++) begin
      idleInputs();
      runahead    = ($urandom % 8) != 0;
      retireValid = ($urandom % 6) != 0;
      recover     = ($urandom % 40) == 0;
      isTrigger   = ($urandom % 10) == 0;
      isConst     = ($urandom % 8) == 0;
      dstWrite    = ($urandom % 7) != 0;
      srcAUsed    = $urandom % 2;
      srcBUsed    = $urandom % 2;
      srcAIdx     = IDX_W'($urandom % 8);
      srcBIdx     = IDX_W'($urandom % 8);
      dstIdx      = (($urandom % 5) == 0) ? IDX_W'($urandom) : IDX_W'($urandom % 8);
      step("R3 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule